// File: doc/BRIEF.md
# Flash erase timer and status byte

This block supplies the busy and status behaviour of a parallel NOR flash model while it programs and erases. It keeps an 8-bit status byte and a down-counter that advances only on cycles where a prescaled tick enable is high. The command decoder asks it to start a sector erase or a chip erase. The block clears the status byte and counts the erase time down. When the count runs out, the block inverts the completion bit and tells the decoder where to resume. The decoder resumes after the unlock cycles if unlock bypass is active. Otherwise it resumes in read mode with the array mapped for direct reads. In both cases the current command is dropped.

A program request loads the status byte from the data being written, so bit 7 reads back as the complement of the written data bit. Every status read sees the current byte, and bit 6 then inverts, which lets software poll for a toggle. A chip erase is parameterised to last ten times as long as a sector erase. Both durations are counted in ticks, so a simulation can use short values. All the block's pins are single-cycle control strobes and levels. There is no data stream, so no valid/ready handshake is used and nothing at the edge applies back-pressure.

Top module: `flash_busy_status`

## Requirements
- R1: While and after reset, status_o is 8'h00, and busy_o, done_o, resume_bypass_o and resume_read_o are all 0.
- R2: An erase_req_i while busy_o is low starts an erase. From the next cycle status_o is 8'h00 (toggles of R8 aside) and busy_o is 1. erase_chip_i=1 selects a chip erase and erase_chip_i=0 selects a sector erase.
- R3: An erase expires on its SECTOR_TICKS-th (sector) or CHIP_TICKS-th (chip) cycle with tick_i high after the start. From the next cycle busy_o is 0, status bit 7 is inverted and done_o is high for exactly one cycle. With tick_i always high, busy_o is high for exactly that many cycles.
- R4: status_o shows the status byte throughout a status_rd_i cycle. From the next cycle, bit 6 of the byte is inverted.
- R5: A prog_req_i loads the status byte with the bitwise inverse of (prog_data_i AND 8'h80), that is {~prog_data_i[7], 7'h7F}.
- R6: At the cycle of done_o, resume_bypass_o is 1 if bypass_i was high in the expiry cycle. Otherwise resume_read_o is 1. Exactly one of them is high, and only together with done_o.
- R7: An erase_req_i while busy_o is high is ignored. The countdown is neither reloaded nor changed in kind, and the status byte is untouched.
- R8: Same-cycle priority for the next status byte: an erase start comes first, then a program load, then the held value. The read toggle (bit 6) and the expiry flip (bit 7) are applied on top of that choice.
- R9: On cycles with tick_i low the countdown holds, so busy_o stays high and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaled time-base enable for the countdown |
| erase_req_i | input | 1 | Erase start strobe from the command decoder |
| erase_chip_i | input | 1 | Erase kind with erase_req_i: 1 chip, 0 sector |
| prog_req_i | input | 1 | Program strobe; loads status from prog_data_i |
| prog_data_i | input | 8 | Data byte being programmed |
| status_rd_i | input | 1 | Status read strobe |
| bypass_i | input | 1 | Unlock bypass currently active |
| status_o | output | 8 | Current status byte |
| busy_o | output | 1 | Erase countdown running |
| done_o | output | 1 | One-cycle pulse after expiry; decoder clears its command |
| resume_bypass_o | output | 1 | With done_o: resume at the post-unlock cycle |
| resume_read_o | output | 1 | With done_o: resume in read mode, array mapped |

## Verification
Status reads can fall in the same cycle as a countdown expiry, a program load or an erase start. These pairs all compete for the same status byte. The bench provokes the expiry collision by holding status_rd_i high for a whole erase, so one read lands on the expiry edge. The expected byte must then show both bit 7 inverted and bit 6 toggled. A behavioural reference model applies the R8 priority rules on every clock. It is compared with all outputs across directed collisions and a long pseudo-random stretch.

// File: rtl/flash_busy_status_pkg.sv
package flash_busy_status_pkg;
  localparam int STAT_W     = 8;
  localparam int DONE_BIT   = 7;
  localparam int TOGGLE_BIT = 6;
  localparam logic [STAT_W-1:0] DONE_MASK   = STAT_W'(1) << DONE_BIT;
  localparam logic [STAT_W-1:0] TOGGLE_MASK = STAT_W'(1) << TOGGLE_BIT;
  localparam logic [STAT_W-1:0] ERASE_CLEAR = '0;

  typedef enum logic {
    KIND_SECTOR = 1'b0,
    KIND_CHIP   = 1'b1
  } erase_kind_e;
endpackage

// File: rtl/fbs_countdown.sv
module fbs_countdown
  import flash_busy_status_pkg::*;
#(
  parameter int SECTOR_TICKS = 5,
  parameter int CHIP_TICKS   = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        start_i,
  input  erase_kind_e kind_i,
  output logic        busy_o,
  output logic        expire_o
);
  localparam int MAX_TICKS = (CHIP_TICKS > SECTOR_TICKS) ? CHIP_TICKS : SECTOR_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] LOAD_SECTOR = CNT_W'(SECTOR_TICKS);
  localparam logic [CNT_W-1:0] LOAD_CHIP   = CNT_W'(CHIP_TICKS);
  localparam logic [CNT_W-1:0] LAST        = CNT_W'(1);

  logic [CNT_W-1:0] remain_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = (kind_i == KIND_CHIP) ? LOAD_CHIP : LOAD_SECTOR;
  assign busy_o   = (remain_q != '0);
  assign expire_o = tick_i && (remain_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (start_i && !busy_o) begin
      remain_q <= load_val;
    end else if (tick_i && busy_o) begin
      remain_q <= remain_q - LAST;
    end
  end
endmodule

// File: rtl/fbs_status_reg.sv
module fbs_status_reg
  import flash_busy_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_start_i,
  input  logic              prog_i,
  input  logic [STAT_W-1:0] prog_data_i,
  input  logic              rd_i,
  input  logic              expire_i,
  output logic [STAT_W-1:0] status_o
);
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] base;
  logic [STAT_W-1:0] flips;

  always_comb begin
    if (erase_start_i) begin
      base = ERASE_CLEAR;
    end else if (prog_i) begin
      base = ~(prog_data_i & DONE_MASK);
    end else begin
      base = stat_q;
    end
    flips = (expire_i ? DONE_MASK : '0) | (rd_i ? TOGGLE_MASK : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= base ^ flips;
    end
  end

  assign status_o = stat_q;
endmodule

// File: rtl/fbs_resume.sv
module fbs_resume (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic bypass_i,
  output logic done_o,
  output logic to_bypass_o,
  output logic to_read_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o      <= 1'b0;
      to_bypass_o <= 1'b0;
      to_read_o   <= 1'b0;
    end else begin
      done_o      <= expire_i;
      to_bypass_o <= expire_i && bypass_i;
      to_read_o   <= expire_i && !bypass_i;
    end
  end
endmodule

// File: rtl/flash_busy_status.sv
module flash_busy_status
  import flash_busy_status_pkg::*;
#(
  parameter int SECTOR_TICKS = 5,
  parameter int CHIP_TICKS   = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        erase_req_i,
  input  logic        erase_chip_i,
  input  logic        prog_req_i,
  input  logic [7:0]  prog_data_i,
  input  logic        status_rd_i,
  input  logic        bypass_i,
  output logic [7:0]  status_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        resume_bypass_o,
  output logic        resume_read_o
);
  logic        busy;
  logic        expire;
  logic        erase_start;
  erase_kind_e kind;

  assign kind        = erase_chip_i ? KIND_CHIP : KIND_SECTOR;
  assign erase_start = erase_req_i && !busy;

  fbs_countdown #(
    .SECTOR_TICKS(SECTOR_TICKS),
    .CHIP_TICKS  (CHIP_TICKS)
  ) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .start_i (erase_start),
    .kind_i  (kind),
    .busy_o  (busy),
    .expire_o(expire)
  );

  fbs_status_reg u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .erase_start_i(erase_start),
    .prog_i       (prog_req_i),
    .prog_data_i  (prog_data_i),
    .rd_i         (status_rd_i),
    .expire_i     (expire),
    .status_o     (status_o)
  );

  fbs_resume u_resume (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire_i   (expire),
    .bypass_i   (bypass_i),
    .done_o     (done_o),
    .to_bypass_o(resume_bypass_o),
    .to_read_o  (resume_read_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/flash_busy_status_chk.sv
module flash_busy_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       erase_req_i,
  input logic       prog_req_i,
  input logic [7:0] prog_data_i,
  input logic       status_rd_i,
  input logic       bypass_i,
  input logic [7:0] status_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       resume_bypass_o,
  input logic       resume_read_o
);
  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (status_o == 8'h00 && !busy_o && !done_o) else $error("reset state"); // R1
    end
  end

  AST_ERASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req_i && !busy_o && !status_rd_i |=> status_o == 8'h00 && busy_o); // R2

  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R3

  AST_EXPIRY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) && !$past(status_rd_i) && !$past(prog_req_i)
      |-> status_o == ($past(status_o) ^ 8'h80)); // R3

  AST_READ_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd_i && !prog_req_i && !(erase_req_i && !busy_o)
      |=> status_o[6] != $past(status_o[6])); // R4

  AST_PROG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req_i && !busy_o && !erase_req_i && !status_rd_i
      |=> status_o == {~$past(prog_data_i[7]), 7'h7F}); // R5

  AST_ROUTE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o == (resume_bypass_o || resume_read_o) && !(resume_bypass_o && resume_read_o)); // R6

  AST_ROUTE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> resume_bypass_o == $past(bypass_i)); // R6

  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !tick_i |=> busy_o && !done_o); // R9
endmodule

bind flash_busy_status flash_busy_status_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tick_i         (tick_i),
  .erase_req_i    (erase_req_i),
  .prog_req_i     (prog_req_i),
  .prog_data_i    (prog_data_i),
  .status_rd_i    (status_rd_i),
  .bypass_i       (bypass_i),
  .status_o       (status_o),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .resume_bypass_o(resume_bypass_o),
  .resume_read_o  (resume_read_o)
);

// File: tb/sim_flash_busy_status.sv
`timescale 1ns/1ps
module sim_flash_busy_status;
  localparam int S_TICKS = 5;
  localparam int C_TICKS = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       erase_req_i = 1'b0;
  logic       erase_chip_i = 1'b0;
  logic       prog_req_i = 1'b0;
  logic [7:0] prog_data_i = 8'h00;
  logic       status_rd_i = 1'b0;
  logic       bypass_i = 1'b0;
  logic [7:0] status_o;
  logic       busy_o, done_o, resume_bypass_o, resume_read_o;

  always #2.5 clk = ~clk;

  flash_busy_status #(.SECTOR_TICKS(S_TICKS), .CHIP_TICKS(C_TICKS)) u0 (.*);

  int checks = 0;
  int failures = 0;
  string tag = "R1";

  // behavioural reference state
  int       m_left = 0;
  bit [7:0] m_stat = 8'h00;
  bit       m_done = 0, m_rb = 0, m_rr = 0;

  task automatic check(input string t, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s got=%0h exp=%0h", t, what, got, exp);
    end
  endtask

  task automatic compare_all();
    check(tag, "status", status_o, m_stat);
    check(tag, "busy", busy_o, (m_left != 0));
    check(tag, "done", done_o, m_done);
    check(tag, "resume_bypass", resume_bypass_o, m_rb);
    check(tag, "resume_read", resume_read_o, m_rr);
  endtask

  // one cycle: compare at negedge, then drive inputs and advance the model
  task automatic step(input bit er, input bit chip, input bit pr, input bit [7:0] d,
                      input bit rd, input bit byp, input bit tk);
    bit start, exp;
    bit [7:0] base;
    @(negedge clk);
    compare_all();
    erase_req_i = er; erase_chip_i = chip; prog_req_i = pr; prog_data_i = d;
    status_rd_i = rd; bypass_i = byp; tick_i = tk;
    start = er && (m_left == 0);
    exp   = !start && tk && (m_left == 1);
    if (start) base = 8'h00;
    else if (pr) base = {~d[7], 7'h7F};
    else base = m_stat;
    m_stat = base ^ {exp, rd, 6'b0};
    if (start) m_left = chip ? C_TICKS : S_TICKS;
    else if (tk && m_left > 0) m_left = m_left - 1;
    m_done = exp; m_rb = exp && byp; m_rr = exp && !byp;
  endtask

  task automatic idle(input int n, input bit byp = 0);
    for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00, 0, byp, 1);
  endtask

  // measure busy length with tick always high, independent of the model
  task automatic measure(input bit chip, input int exp_len, input string t);
    int len = 0;
    step(1, chip, 0, 8'h00, 0, 0, 1);
    for (int i = 0; i < exp_len + 4; i++) begin
      step(0, 0, 0, 8'h00, 0, 0, 1);
      if (busy_o) len++;
    end
    check(t, "busy length", len, exp_len);
  endtask

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    check("R1", "reset status", status_o, 8'h00);
    check("R1", "reset busy", busy_o, 0);
    rst_n = 1'b1;
    idle(3);

    tag = "R3"; measure(0, S_TICKS, "R3");
    measure(1, C_TICKS, "R3");
    idle(2);

    tag = "R2"; step(1, 0, 0, 8'h00, 0, 0, 1);
    idle(S_TICKS + 2);

    tag = "R4"; for (int i = 0; i < 5; i++) step(0, 0, 0, 8'h00, 1, 0, 1);
    idle(1);

    tag = "R5"; step(0, 0, 1, 8'h80, 0, 0, 1); idle(1);
    step(0, 0, 1, 8'h35, 0, 0, 1); idle(1);

    tag = "R6"; step(1, 0, 0, 8'h00, 0, 1, 1); idle(S_TICKS + 2, 1);
    step(1, 0, 0, 8'h00, 0, 0, 1); idle(S_TICKS + 2);

    tag = "R7"; step(1, 0, 0, 8'h00, 0, 0, 1);
    step(1, 1, 0, 8'h00, 0, 0, 1);
    step(1, 1, 0, 8'h00, 0, 0, 1);
    idle(S_TICKS + 2);

    tag = "R8";
    step(0, 0, 1, 8'h00, 1, 0, 1); idle(1);
    step(1, 0, 1, 8'hFF, 1, 0, 1);
    for (int i = 0; i < S_TICKS + 2; i++) step(0, 0, 0, 8'h00, 1, 0, 1);
    step(1, 0, 0, 8'h00, 0, 0, 1);
    for (int i = 0; i < S_TICKS + 2; i++) step(0, 0, 1, 8'h80, 0, 0, 1);

    tag = "R9"; step(1, 0, 0, 8'h00, 0, 0, 0);
    for (int i = 0; i < 4 * S_TICKS; i++) step(0, 0, 0, 8'h00, 0, 0, (i % 3) == 2);
    idle(3);

    tag = "R8";
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom;
      step(r[3:0] == 0, r[4], r[9:7] == 0, 8'(r >> 12), r[11:10] == 0, r[20], r[23:21] != 0);
    end
    idle(C_TICKS + 2);
    @(negedge clk); compare_all();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired in %s", tag);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule